// File: doc/BRIEF.md
# Partitioned SIMD Adder and Logic Unit

This unit works on 64-bit operands split into eight byte lanes. Seven gate bits, one between each pair of neighbouring lanes, decide at run time where the lanes join. A set gate bit opens a boundary. A clear gate bit fuses the two lanes into one wider field. Fields can therefore be any length from 8 to 64 bits in steps of one byte, and that includes lengths that are not a power of two, such as 24 or 40 bits.

A 3-bit opcode selects the operation. The arithmetic operations are add, subtract and negate. They run on one shared ripple chain. That chain is cut at every open boundary, so no carry or borrow ever leaks from one field into the next. Each field receives its own result, wrapped to the field width. The bitwise operations (and, or, xor, not and implies) act on all 64 bits and ignore the gates.

The result is captured in an output register with a synchronous active-high reset. A result therefore appears one clock after its inputs.

Top module: `psimd_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_q` becomes 0 at that edge.
- R2: With opcode 0 (add), every field of `res_q` equals the sum of the matching fields of `op_a` and `op_b`, taken modulo 2 to the power of the field width. Fields are formed from byte lanes, with lane k at bits 8k+7..8k. Gate bit k lies between lane k and lane k+1.
- R3: With opcode 1 (subtract), every field equals the field of `op_a` minus the field of `op_b`, modulo the field width.
- R4: With opcode 2 (negate), every field equals the two's-complement negative of the field of `op_a`, modulo the field width. `op_b` has no effect on the result.
- R5: A carry or borrow never crosses an open boundary. Each field's result depends only on the operand bits inside that field.
- R6: Opcodes 3, 4 and 5 (and, or, xor) give the bitwise result on all 64 bits, whatever the gate bits are.
- R7: Opcode 6 (not) gives the bitwise inverse of `op_a`. `op_b` and the gate bits have no effect on the result.
- R8: Opcode 7 (implies) gives (NOT `op_a`) OR `op_b` in every bit position.
- R9: `res_q` changes only at a rising clock edge, and it then shows the result for the inputs sampled at that edge.
- R10: With every gate bit set, each byte lane adds on its own (eight independent 8-bit operations). With no gate bit set, the whole word is one 64-bit operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Opcode: add=0, sub=1, neg=2, and=3, or=4, xor=5, not=6, implies=7 |
| lane_gate | input | 7 | Bit k set opens a boundary between lane k and lane k+1 |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| res_q | output | 64 | Registered result |

## Verification
Each opcode is run under all 128 gate patterns with random operands. This shows whether every possible combination of field lengths and offsets is cut at the right lane, including the odd-length fields.

Directed operands of all-zero, all-ones and top-bit-per-lane force carries and borrows to ripple through whole fields. A leak across a boundary then shows up as a wrong neighbouring field. This case is told apart from a carry that stops early inside a field.

Runs with every gate open and with every gate closed compare the extreme cases: eight separate byte lanes against a single 64-bit word.

Changing `op_b` under negate and not, and sampling before the clock edge, show that ignored inputs really have no effect and that the result waits for the register.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_NEG  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_NOT  = 3'd6,
    OP_IMPL = 3'd7
  } psimd_op_e;

  function automatic logic is_arith(input psimd_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
  endfunction

endpackage

// File: rtl/psimd_operand_sel.sv
module psimd_operand_sel
  import psimd_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  psimd_op_e         op,
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  output logic [WIDTH-1:0]  x,
  output logic [WIDTH-1:0]  y,
  output logic              cin_base
);

  always_comb begin
    x        = a;
    y        = b;
    cin_base = 1'b0;
    unique case (op)
      OP_SUB: begin
        y        = ~b;
        cin_base = 1'b1;
      end
      OP_NEG: begin
        x        = '0;
        y        = ~a;
        cin_base = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/psimd_carry_lanes.sv
module psimd_carry_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 8,
  localparam int WIDTH = LANE_W * LANES
) (
  input  logic [WIDTH-1:0]  x,
  input  logic [WIDTH-1:0]  y,
  input  logic [LANES-2:0]  gate,
  input  logic              cin_base,
  output logic [WIDTH-1:0]  sum
);

  logic [LANES-1:0] lane_cin;
  logic [LANES-1:0] lane_cout;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W:0] wide;

    if (l == 0) begin : g_first
      assign lane_cin[l] = cin_base;
    end else begin : g_rest
      // an open boundary below this lane restarts the chain
      assign lane_cin[l] = gate[l-1] ? cin_base : lane_cout[l-1];
    end

    assign wide = {1'b0, x[l*LANE_W +: LANE_W]}
                + {1'b0, y[l*LANE_W +: LANE_W]}
                + {{LANE_W{1'b0}}, lane_cin[l]};
    assign sum[l*LANE_W +: LANE_W] = wide[LANE_W-1:0];
    assign lane_cout[l]            = wide[LANE_W];
  end

endmodule

// File: rtl/psimd_bitwise.sv
module psimd_bitwise
  import psimd_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  psimd_op_e         op,
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  output logic [WIDTH-1:0]  r
);

  always_comb begin
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOT:  r = ~a;
      OP_IMPL: r = ~a | b;
      default: r = '0;
    endcase
  end

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
  import psimd_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 8,
  localparam int WIDTH = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_sel,
  input  logic [LANES-2:0]  lane_gate,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  output logic [WIDTH-1:0]  res_q
);

  psimd_op_e        op;
  logic [WIDTH-1:0] x, y, arith_r, logic_r, next_r;
  logic             cin_base;

  assign op = psimd_op_e'(op_sel);

  psimd_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .op(op), .a(op_a), .b(op_b), .x(x), .y(y), .cin_base(cin_base)
  );

  psimd_carry_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_chain (
    .x(x), .y(y), .gate(lane_gate), .cin_base(cin_base), .sum(arith_r)
  );

  psimd_bitwise #(.WIDTH(WIDTH)) u_bit (
    .op(op), .a(op_a), .b(op_b), .r(logic_r)
  );

  assign next_r = is_arith(op) ? arith_r : logic_r;

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= next_r;
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_q == '0));

  p_word_add_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd0 && lane_gate == '0) |=> (res_q == $past(op_a) + $past(op_b)));

  p_word_sub_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd1 && lane_gate == '0) |=> (res_q == $past(op_a) - $past(op_b)));

  p_word_neg_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd2 && lane_gate == '0) |=> (res_q == '0 - $past(op_a)));

  p_and_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd3) |=> (res_q == ($past(op_a) & $past(op_b))));

  p_or_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd4) |=> (res_q == ($past(op_a) | $past(op_b))));

  p_xor_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd5) |=> (res_q == ($past(op_a) ^ $past(op_b))));

  p_not_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd6) |=> (res_q == ~$past(op_a)));

  p_implies_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd7) |=> (res_q == (~$past(op_a) | $past(op_b))));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    p_lane_add_r5: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 3'd0 && lane_gate == '1) |=>
      (res_q[l*LANE_W +: LANE_W] ==
       LANE_W'($past(op_a[l*LANE_W +: LANE_W]) + $past(op_b[l*LANE_W +: LANE_W]))));
  end

endmodule

// File: tb/psimd_alu_test.sv
`timescale 1ns/1ps
module psimd_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = 3'd0;
  logic [6:0]  lane_gate = 7'd0;
  logic [63:0] op_a = 64'd0;
  logic [63:0] op_b = 64'd0;
  logic [63:0] res_q;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  psimd_alu uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .lane_gate(lane_gate),
    .op_a(op_a), .op_b(op_b), .res_q(res_q)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic [6:0] g,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] res, mask, fa, fb, r;
    int s, w;
    case (op)
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      3'd6: return ~a;
      3'd7: return ~a | b;
      default: ;
    endcase
    res = '0;
    s = 0;
    for (int i = 0; i < 8; i++) begin
      if (i == 7 || g[i]) begin
        w    = (i - s + 1) * 8;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        fa   = (a >> (8 * s)) & mask;
        fb   = (b >> (8 * s)) & mask;
        r    = (op == 3'd0) ? fa + fb : (op == 3'd1) ? fa - fb : 64'd0 - fa;
        res  = res | ((r & mask) << (8 * s));
        s    = i + 1;
      end
    end
    return res;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd6: return "R7";
      3'd7: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [2:0] op, input logic [6:0] g,
                     input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_sel = op; lane_gate = g; op_a = a; op_b = b;
    @(posedge clk);
    #1;
    check(req, res_q, model(op, g, a, b));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    void'($urandom(32'd1234));
    // R1: reset clears the register
    op_a = '1; op_b = '1; op_sel = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", res_q, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2..R8: every opcode under every gate pattern
    for (int op = 0; op < 8; op++)
      for (int g = 0; g < 128; g++)
        run(tag_of(3'(op)), 3'(op), 7'(g), rnd64(), rnd64());

    // R5: edge operands ripple through whole fields
    for (int g = 0; g < 128; g++) begin
      run("R5", 3'd0, 7'(g), '1, 64'h0101010101010101);
      run("R5", 3'd1, 7'(g), 64'd0, 64'h0101010101010101);
      run("R5", 3'd0, 7'(g), 64'h8080808080808080, 64'h8080808080808080);
      run("R5", 3'd2, 7'(g), 64'h0000000000000001, '1);
    end
    // R5: explicit expected value, two 32-bit fields
    run("R5", 3'd0, 7'b0001000, '1, 64'd1);
    check("R5", res_q, 64'hFFFFFFFF00000000);

    // R10: both extremes of the gates
    run("R10", 3'd0, 7'b1111111, '1, 64'h0101010101010101);
    check("R10", res_q, 64'd0);
    run("R10", 3'd0, 7'b0000000, '1, 64'd1);
    check("R10", res_q, 64'd0);
    run("R10", 3'd1, 7'b1111111, 64'd0, 64'h0101010101010101);
    check("R10", res_q, '1);

    // R4 / R7: op_b has no effect
    run("R4", 3'd2, 7'b0100101, 64'h123456789ABCDEF0, 64'd0);
    prev = res_q;
    run("R4", 3'd2, 7'b0100101, 64'h123456789ABCDEF0, '1);
    check("R4", res_q, prev);
    run("R7", 3'd6, 7'b0000000, 64'hA5A5A5A5A5A5A5A5, 64'd0);
    prev = res_q;
    run("R7", 3'd6, 7'b1111111, 64'hA5A5A5A5A5A5A5A5, '1);
    check("R7", res_q, prev);

    // R6: gates have no effect on the bitwise ops
    run("R6", 3'd5, 7'b0000000, 64'hFF00FF00FF00FF00, 64'h0F0F0F0F0F0F0F0F);
    check("R6", res_q, 64'hF00FF00FF00FF00F);

    // R9: output holds until the clock edge
    @(negedge clk);
    prev = res_q;
    op_sel = 3'd3; op_a = 64'd0; op_b = 64'd0;
    #2;
    check("R9", res_q, prev);
    @(posedge clk);
    #1;
    check("R9", res_q, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule